// File: doc/BRIEF.md
# Vector Element Loop Sequencer

The sequencer executes one vectorised integer add or subtract over a 32-entry by 32-bit register file. A start strobe delivers the element count and three operand descriptors. Each descriptor is a base register plus a flag that marks the operand as scalar or vector. The block then issues one element operation per clock until every element has been handled. A vector operand steps its register index with the element number, while a scalar operand stays on its base register.

Element operations are strictly serial. Each one reads its sources combinationally and writes its result on the same clock edge, so the next element already sees that result. A scalar destination does not shorten the loop. When the scalar destination is also a source, it accumulates a running reduction. When it is not a source, only the last issued element's result survives. A reverse flag runs the loop from the highest element down to element 0. This turns overlapping vector operations into suffix-style cumulative chains.

A test port lets a bench or a test controller load and inspect the register file while the sequencer is idle.

Top module: `vec_elem_seq`

## Requirements
- R1: After reset, busy and done are low and every register reads zero on the test read port.
- R2: For element e, a vector operand addresses register (base + e) mod 32 and a scalar operand addresses its base register.
- R3: With the reverse flag at 0, elements issue in order 0, 1, ..., VL-1, and each element reads values already written by earlier elements.
- R4: With the reverse flag at 1, elements issue in order VL-1 down to 0, with the same read-after-write chaining.
- R5: With a scalar destination that is not a source, all VL elements still issue, and the destination ends with the result of the last issued element.
- R6: With a scalar destination equal to a scalar source, the destination ends holding the running reduction over all elements.
- R7: Operation select 0 writes ra + rb and select 1 writes ra - rb, both modulo 2^32.
- R8: For VL from 1 to 16, busy is high for exactly VL cycles starting the cycle after start. Done is high for exactly the one cycle after the final write.
- R9: A start with VL = 0 leaves busy low, raises done on the next cycle only, and changes no register.
- R10: Start and its fields are ignored while busy.
- R11: The test write port writes while idle and is ignored while busy. The test read port returns the addressed register combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Launch strobe, taken only while idle |
| op_sub | input | 1 | 0 = add, 1 = subtract (ra - rb) |
| rev | input | 1 | 1 = descending element order |
| vl | input | 5 | Element count, 0 to 16 |
| rt_base | input | 5 | Destination base register |
| rt_vec | input | 1 | Destination is a vector |
| ra_base | input | 5 | First source base register |
| ra_vec | input | 1 | First source is a vector |
| rb_base | input | 5 | Second source base register |
| rb_vec | input | 1 | Second source is a vector |
| tw_en | input | 1 | Test write enable |
| tw_addr | input | 5 | Test write register |
| tw_data | input | 32 | Test write value |
| dbg_addr | input | 5 | Test read register |
| dbg_data | output | 32 | Test read value |
| busy | output | 1 | Element loop in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The assertions assume that start is low during reset and that vl never exceeds 16. A larger count would break the bound between the element counter and the latched length. The random stimulus draws vl from 0 to 16 and applies start only through a task that waits for idle, except for deliberate injections while busy. Those injections carry legal fields, so every checked property stays within the assumed input range.

// File: rtl/vec_elem_seq.sv
module vec_elem_seq #(
  parameter int XLEN  = 32,
  parameter int NREG  = 32,
  parameter int MAXVL = 16,
  localparam int AW = $clog2(NREG),
  localparam int VW = $clog2(MAXVL + 1),
  localparam int CW = $clog2(MAXVL)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic            op_sub,
  input  logic            rev,
  input  logic [VW-1:0]   vl,
  input  logic [AW-1:0]   rt_base,
  input  logic            rt_vec,
  input  logic [AW-1:0]   ra_base,
  input  logic            ra_vec,
  input  logic [AW-1:0]   rb_base,
  input  logic            rb_vec,
  input  logic            tw_en,
  input  logic [AW-1:0]   tw_addr,
  input  logic [XLEN-1:0] tw_data,
  input  logic [AW-1:0]   dbg_addr,
  output logic [XLEN-1:0] dbg_data,
  output logic            busy,
  output logic            done
);

  logic [XLEN-1:0] rf [NREG];

  logic          sub_q, rev_q;
  logic [VW-1:0] vl_q;
  logic [AW-1:0] rt_q, ra_q, rb_q;
  logic          rtv_q, rav_q, rbv_q;
  logic [CW-1:0] cnt;

  logic [CW-1:0]   elem;
  logic [AW-1:0]   rt_i, ra_i, rb_i;
  logic [XLEN-1:0] ra_v, rb_v, res;
  logic            last;

  assign elem = rev_q ? CW'(vl_q - VW'(1) - VW'(cnt)) : cnt;
  assign rt_i = rt_q + (rtv_q ? AW'(elem) : '0);
  assign ra_i = ra_q + (rav_q ? AW'(elem) : '0);
  assign rb_i = rb_q + (rbv_q ? AW'(elem) : '0);
  assign ra_v = rf[ra_i];
  assign rb_v = rf[rb_i];
  assign res  = sub_q ? ra_v - rb_v : ra_v + rb_v;
  assign last = (VW'(cnt) == vl_q - VW'(1));
  assign dbg_data = rf[dbg_addr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
      busy  <= 1'b0;
      done  <= 1'b0;
      cnt   <= '0;
      vl_q  <= '0;
      sub_q <= 1'b0;
      rev_q <= 1'b0;
      rt_q  <= '0;
      ra_q  <= '0;
      rb_q  <= '0;
      rtv_q <= 1'b0;
      rav_q <= 1'b0;
      rbv_q <= 1'b0;
    end else begin
      done <= 1'b0;
      if (busy) begin
        rf[rt_i] <= res;
        if (last) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          cnt <= cnt + CW'(1);
        end
      end else begin
        if (tw_en) rf[tw_addr] <= tw_data;
        if (start) begin
          vl_q  <= vl;
          sub_q <= op_sub;
          rev_q <= rev;
          rt_q  <= rt_base;
          ra_q  <= ra_base;
          rb_q  <= rb_base;
          rtv_q <= rt_vec;
          rav_q <= ra_vec;
          rbv_q <= rb_vec;
          cnt   <= '0;
          if (vl == '0) done <= 1'b1;
          else          busy <= 1'b1;
        end
      end
    end
  end

endmodule

module vec_elem_seq_chk #(
  parameter int VW = 5,
  parameter int CW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          start,
  input logic [VW-1:0] vl,
  input logic          busy,
  input logic          done,
  input logic [VW-1:0] vl_q,
  input logic [CW-1:0] cnt
);

  // R8
  busy_done_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  // R8
  busy_needs_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  // R9
  zero_len_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && vl == '0) |=> (done && !busy));

  // R10
  len_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(vl_q));

  // R3
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (VW'(cnt) < vl_q));

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

endmodule

bind vec_elem_seq vec_elem_seq_chk #(.VW(VW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .vl(vl),
  .busy(busy), .done(done), .vl_q(vl_q), .cnt(cnt)
);

// File: tb/vec_elem_seq_bench.sv
module vec_elem_seq_bench;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0, op_sub = 1'b0, rev = 1'b0;
  logic [4:0]  vl = '0, rt_base = '0, ra_base = '0, rb_base = '0;
  logic        rt_vec = 1'b0, ra_vec = 1'b0, rb_vec = 1'b0;
  logic        tw_en = 1'b0;
  logic [4:0]  tw_addr = '0, dbg_addr = '0;
  logic [31:0] tw_data = '0, dbg_data;
  logic        busy, done;

  int checks = 0, fails = 0;
  logic [31:0] model [32];

  always #4 clk = ~clk;

  vec_elem_seq u_vec_elem_seq (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input int a, input logic [31:0] d);
    @(negedge clk);
    tw_en = 1'b1; tw_addr = 5'(a); tw_data = d;
    @(negedge clk);
    tw_en = 1'b0;
    model[a] = d;
  endtask

  task automatic verify_rf(input string req);
    for (int i = 0; i < 32; i++) begin
      dbg_addr = 5'(i);
      #1;
      chk(req, dbg_data, model[i]);
    end
  endtask

  function automatic void ref_exec(input bit s, input bit r, input int n,
      input int t, input bit tv, input int a, input bit av, input int b, input bit bv);
    for (int k = 0; k < n; k++) begin
      int e;
      logic [31:0] x, y;
      e = r ? n - 1 - k : k;
      x = model[(a + (av ? e : 0)) % 32];
      y = model[(b + (bv ? e : 0)) % 32];
      model[(t + (tv ? e : 0)) % 32] = s ? x - y : x + y;
    end
  endfunction

  task automatic run(input string req, input bit s, input bit r, input int n,
      input int t, input bit tv, input int a, input bit av, input int b, input bit bv,
      input bit inject);
    int cyc;
    @(negedge clk);
    start = 1'b1; op_sub = s; rev = r; vl = 5'(n);
    rt_base = 5'(t); rt_vec = tv; ra_base = 5'(a); ra_vec = av; rb_base = 5'(b); rb_vec = bv;
    @(negedge clk);
    start = 1'b0;
    cyc = 0;
    while (busy && cyc < 40) begin
      cyc++;
      if (inject && cyc == 1) begin
        start = 1'b1; vl = 5'd3; op_sub = ~s; rt_base = 5'd9;
        tw_en = 1'b1; tw_addr = 5'd5; tw_data = 32'hDEAD_BEEF;
      end else begin
        start = 1'b0; tw_en = 1'b0;
      end
      @(negedge clk);
    end
    start = 1'b0; tw_en = 1'b0;
    chk({"R8 busy length ", req}, 32'(cyc), 32'(n));
    chk({"R8 done pulse ", req}, 32'(done), 32'd1);
    @(negedge clk);
    chk({"R8 done width ", req}, 32'(done), 32'd0);
    ref_exec(s, r, n, t, tv, a, av, b, bv);
    verify_rf(req);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1234_5678));
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 busy", 32'(busy), 0);
    chk("R1 done", 32'(done), 0);
    verify_rf("R1 regs");

    // R11 test write visible when idle
    for (int i = 0; i < 32; i++) load(i, 32'(i * 3 + 1));
    verify_rf("R11 test write");

    // R6 R3 accumulator forward: r0 += r8..r15
    run("R6 accum fwd", 1'b0, 1'b0, 8, 0, 1'b0, 0, 1'b0, 8, 1'b1, 1'b0);
    // R6 R4 accumulator reverse with subtract (R7)
    run("R6 R7 accum rev sub", 1'b1, 1'b1, 6, 1, 1'b0, 1, 1'b0, 20, 1'b1, 1'b0);
    // R5 scalar destination not a source, forward and reverse
    run("R5 last fwd", 1'b0, 1'b0, 5, 2, 1'b0, 10, 1'b1, 16, 1'b1, 1'b0);
    run("R5 last rev", 1'b0, 1'b1, 5, 2, 1'b0, 10, 1'b1, 16, 1'b1, 1'b0);
    // R4 reverse vector chain: dst base 3, sources base 4
    run("R4 rev chain", 1'b0, 1'b1, 7, 3, 1'b1, 4, 1'b1, 4, 1'b1, 1'b0);
    // R3 forward overlapping chain: dst base 5, sources base 4
    run("R3 fwd chain", 1'b0, 1'b0, 7, 5, 1'b1, 4, 1'b1, 4, 1'b1, 1'b0);
    // R2 index wrap modulo 32
    run("R2 wrap", 1'b1, 1'b0, 6, 29, 1'b1, 30, 1'b1, 2, 1'b0, 1'b0);
    // R9 zero length
    run("R9 vl0", 1'b0, 1'b0, 0, 0, 1'b0, 0, 1'b0, 1, 1'b1, 1'b0);
    // R8 full length
    run("R8 vl16", 1'b0, 1'b1, 16, 16, 1'b1, 0, 1'b1, 31, 1'b0, 1'b0);
    // R10 R11 start and test write ignored while busy
    run("R10 R11 inject", 1'b0, 1'b0, 6, 7, 1'b1, 12, 1'b1, 0, 1'b0, 1'b1);

    for (int n = 0; n < 40; n++) begin
      if (n % 8 == 0)
        for (int i = 0; i < 32; i++) load(i, $urandom);
      run("R2 R3 R4 R7 random", 1'($urandom), 1'($urandom), int'($urandom % 17),
          int'($urandom % 32), 1'($urandom), int'($urandom % 32), 1'($urandom),
          int'($urandom % 32), 1'($urandom), 1'($urandom % 4 == 0));
    end

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule